// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timer

This block times a single access on an 8080-style parallel display bus. A one-clock start pulse launches either a write or a read. From then on, an internal tick counter runs from zero and drives three active-high strobes: chip-select, write-enable and read-enable. Each strobe has its own programmable on tick and off tick. A read also produces a one-clock capture pulse at the programmed access tick, which tells the data path when to latch the panel's read data. Every access ends with a one-clock done pulse.

The timing arrives as two packed words. One word holds the strobe edges and the other holds the cycle lengths and the access time. Both words are sampled together with the access type and the granularity select on the start clock, so they may change freely while an access runs.

Before the values are used, the block corrects them so that the bus ordering always holds:

- Each strobe releases after it asserts.
- Chip-select covers the other strobes' release edges.
- The cycle is at least as long as the active strobe.
- Read data is sampled after read-enable goes active.

A granularity select stretches every tick to two clocks, which suits slow panels.

Top module: `pbus_strobe_timer`

## Requirements
- R1: While reset is high, and on the first clock after it falls, all five outputs are low. An access in progress is abandoned by reset.
- R2: Strobe on ticks are 4-bit fields and off ticks are 6-bit fields, packed in the edge word as follows: chip-select on in bits 3:0, chip-select off in 9:4, write-enable on in 13:10, write-enable off in 19:14, read-enable on in 23:20, read-enable off in 29:24. In the cycle word, the write cycle length sits in bits 5:0, the read cycle length in 11:6 and the read access tick in 27:22. Bits 17:12 and all other bits are not used.
- R3: A strobe is high while the tick count is at or above its on tick and below its corrected off tick. Chip-select is used on both access types. Only write-enable toggles on a write (rd_i = 0), and only read-enable toggles on a read (rd_i = 1).
- R4: An off tick that is less than or equal to its on tick is replaced by the on tick plus one.
- R5: The chip-select off tick is raised to the largest of its own corrected value and the corrected write-enable and read-enable off ticks. This holds for both access types.
- R6: The cycle length is the write cycle field raised to at least the corrected write-enable off tick (writes), or the read cycle field raised to at least the corrected read-enable off tick (reads). done_o is high for exactly the last clock of the tick whose count equals the cycle length. All outputs are low from the following clock.
- R7: On a read, the access tick is replaced by read-enable on plus one when it does not exceed read-enable on. capture_o is high for the last clock of that tick. capture_o never pulses on a write.
- R8: With slow_i = 0, one tick lasts one clock. With slow_i = 1, one tick lasts two clocks. The setting is taken at start.
- R9: A start pulse during an access, including its done clock, is ignored. The running access keeps its sampled timing and type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-clock request to begin an access |
| rd_i | input | 1 | Access type: 1 read, 0 write |
| slow_i | input | 1 | Tick granularity: 1 two clocks per tick, 0 one clock |
| onoff_i | input | WORD_W | Packed strobe on/off ticks |
| cycle_i | input | WORD_W | Packed cycle lengths and read access tick |
| cs_o | output | 1 | Chip-select strobe, active high |
| we_o | output | 1 | Write-enable strobe, active high |
| re_o | output | 1 | Read-enable strobe, active high |
| capture_o | output | 1 | Read data capture pulse |
| done_o | output | 1 | End-of-access pulse |

## Verification
The bench drives several kinds of access and compares every output clock by clock against windows it derives from the requirements.

- **Well-ordered timing, both access types, both granularities.** This separates correct edge placement from off-by-one tick errors. It also shows whether the tick is stretched on the right clock phase.
- **Off ticks at or below their on ticks.** These separate the on-plus-one correction from a pass-through or an off-by-one.
- **Cycle and access fields below their floors.** These catch a missing floor, as does a chip-select release that must be pulled later by another strobe's release.
- **All-maximum fields.** These check the counter at its top value.
- **Reset in mid-access, and a second start with different settings during a running access.** These show that state is cleared and that the running access keeps its sampled settings.

// File: rtl/pbus_timing_pkg.sv
package pbus_timing_pkg;

    localparam int ON_W     = 4;
    localparam int OFF_W    = 6;
    localparam int N_STROBE = 3;
    localparam int FIELD_SPAN = ON_W + OFF_W;
    localparam int EDGE_USED  = N_STROBE * FIELD_SPAN;

    localparam int WCYC_LSB = 0;
    localparam int RCYC_LSB = WCYC_LSB + OFF_W;
    localparam int GAP_LSB  = RCYC_LSB + OFF_W;
    localparam int ACC_LSB  = 22;
    localparam int CYC_USED = ACC_LSB + OFF_W;

    typedef enum int {STB_CS = 0, STB_WE = 1, STB_RE = 2} strobe_e;

    typedef logic [OFF_W-1:0] tick_t;

    typedef struct packed {
        tick_t on;
        tick_t off;
    } win_t;

    typedef struct packed {
        win_t  cs;
        win_t  we;
        win_t  re;
        tick_t cyc;
        tick_t acc;
        logic  rd;
        logic  slow;
    } plan_t;

    function automatic tick_t widen_on(input logic [ON_W-1:0] v);
        return {{(OFF_W-ON_W){1'b0}}, v};
    endfunction

    function automatic tick_t fix_off(input tick_t on, input tick_t off);
        return (off <= on) ? on + tick_t'(1) : off;
    endfunction

    function automatic tick_t tmax(input tick_t a, input tick_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic in_win(input tick_t cnt, input win_t w);
        return (cnt >= w.on) && (cnt < w.off);
    endfunction

endpackage

// File: rtl/pbus_timing_fix.sv
module pbus_timing_fix
    import pbus_timing_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] onoff_i,
    input  logic [WORD_W-1:0] cycle_i,
    input  logic              rd_i,
    input  logic              slow_i,
    output plan_t             plan_o
);

    win_t fixed_win [N_STROBE];

    generate
        for (genvar g = 0; g < N_STROBE; g++) begin : g_win
            localparam int LSB = g * FIELD_SPAN;
            tick_t on_t;
            tick_t off_t;
            assign on_t  = widen_on(onoff_i[LSB +: ON_W]);
            assign off_t = onoff_i[LSB+ON_W +: OFF_W];
            assign fixed_win[g] = '{on: on_t, off: fix_off(on_t, off_t)};
        end
    endgenerate

    logic spare_unused;
    assign spare_unused = ^{onoff_i[WORD_W-1:EDGE_USED],
                            cycle_i[ACC_LSB-1:GAP_LSB],
                            cycle_i[WORD_W-1:CYC_USED]};

    tick_t wr_len, rd_len, acc_raw;

    always_comb begin
        wr_len  = cycle_i[WCYC_LSB +: OFF_W];
        rd_len  = cycle_i[RCYC_LSB +: OFF_W];
        acc_raw = cycle_i[ACC_LSB +: OFF_W];

        plan_o.cs.on  = fixed_win[STB_CS].on;
        plan_o.cs.off = tmax(fixed_win[STB_CS].off,
                             tmax(fixed_win[STB_WE].off, fixed_win[STB_RE].off));
        plan_o.we     = fixed_win[STB_WE];
        plan_o.re     = fixed_win[STB_RE];
        plan_o.cyc    = rd_i ? tmax(rd_len, fixed_win[STB_RE].off)
                             : tmax(wr_len, fixed_win[STB_WE].off);
        plan_o.acc    = (acc_raw <= fixed_win[STB_RE].on)
                        ? fixed_win[STB_RE].on + tick_t'(1) : acc_raw;
        plan_o.rd     = rd_i;
        plan_o.slow   = slow_i;
    end

endmodule

// File: rtl/pbus_tick_div.sv
module pbus_tick_div (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic slow_i,
    output logic tick_end_o
);

    logic phase;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            phase <= 1'b0;
        end else if (slow_i) begin
            phase <= ~phase;
        end
    end

    assign tick_end_o = !slow_i || phase;

endmodule

// File: rtl/pbus_access_seq.sv
module pbus_access_seq
    import pbus_timing_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  plan_t plan_i,
    input  logic  tick_end_i,
    output logic  run_o,
    output logic  slow_o,
    output logic  cs_o,
    output logic  we_o,
    output logic  re_o,
    output logic  capture_o,
    output logic  done_o
);

    plan_t cur;
    logic  run;
    tick_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
            cur <= '0;
        end else if (!run) begin
            if (start_i) begin
                run <= 1'b1;
                cnt <= '0;
                cur <= plan_i;
            end
        end else if (tick_end_i) begin
            if (cnt == cur.cyc) begin
                run <= 1'b0;
                cnt <= '0;
            end else begin
                cnt <= cnt + tick_t'(1);
            end
        end
    end

    logic last_clk;
    assign last_clk  = run && tick_end_i;

    assign run_o     = run;
    assign slow_o    = cur.slow;
    assign cs_o      = run && in_win(cnt, cur.cs);
    assign we_o      = run && !cur.rd && in_win(cnt, cur.we);
    assign re_o      = run &&  cur.rd && in_win(cnt, cur.re);
    assign capture_o = last_clk && cur.rd && (cnt == cur.acc);
    assign done_o    = last_clk && (cnt == cur.cyc);

endmodule

// File: rtl/pbus_strobe_timer.sv
module pbus_strobe_timer
    import pbus_timing_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic              slow_i,
    input  logic [WORD_W-1:0] onoff_i,
    input  logic [WORD_W-1:0] cycle_i,
    output logic              cs_o,
    output logic              we_o,
    output logic              re_o,
    output logic              capture_o,
    output logic              done_o
);

    plan_t plan;
    logic  run;
    logic  cur_slow;
    logic  tick_end;

    pbus_timing_fix #(.WORD_W(WORD_W)) fix_i (
        .onoff_i (onoff_i),
        .cycle_i (cycle_i),
        .rd_i    (rd_i),
        .slow_i  (slow_i),
        .plan_o  (plan)
    );

    pbus_tick_div div_i (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run),
        .slow_i     (cur_slow),
        .tick_end_o (tick_end)
    );

    pbus_access_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .plan_i     (plan),
        .tick_end_i (tick_end),
        .run_o      (run),
        .slow_o     (cur_slow),
        .cs_o       (cs_o),
        .we_o       (we_o),
        .re_o       (re_o),
        .capture_o  (capture_o),
        .done_o     (done_o)
    );

endmodule

// File: rtl/pbus_strobe_timer_chk.sv
module pbus_strobe_timer_chk (
    input logic clk,
    input logic rst,
    input logic cs_o,
    input logic we_o,
    input logic re_o,
    input logic capture_o,
    input logic done_o
);

    // R1: the clock after a reset edge shows no activity
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        rst |=> !(cs_o || we_o || re_o || capture_o || done_o));

    // R3: one access never drives both data strobes
    p_strobe_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(we_o && re_o));

    // R5: chip-select never releases before the data strobes
    p_cs_covers_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_o) |-> !(we_o || re_o));

    // R6: done lasts one clock and the bus goes idle after it
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !(cs_o || we_o || re_o));

    // R7: capture is a single clock and never during a write strobe
    p_capture_single_r7: assert property (@(posedge clk) disable iff (rst)
        capture_o |=> !capture_o);

    p_capture_not_write_r7: assert property (@(posedge clk) disable iff (rst)
        capture_o |-> !we_o);

endmodule

bind pbus_strobe_timer pbus_strobe_timer_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cs_o      (cs_o),
    .we_o      (we_o),
    .re_o      (re_o),
    .capture_o (capture_o),
    .done_o    (done_o)
);

// File: tb/pbus_strobe_timer_tb_top.sv
`timescale 1ns/1ps
module pbus_strobe_timer_tb_top;

    localparam int WORD_W = 32;

    typedef struct packed {
        logic [3:0] cs_on;  logic [5:0] cs_off;
        logic [3:0] we_on;  logic [5:0] we_off;
        logic [3:0] re_on;  logic [5:0] re_off;
        logic [5:0] wcyc;   logic [5:0] rcyc;   logic [5:0] acc;
        logic       rd;     logic       slow;
        logic [5:0] x_cs_off; logic [5:0] x_we_off; logic [5:0] x_re_off;
        logic [5:0] x_cyc;    logic [5:0] x_acc;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,6'd10,4'd2,6'd8,4'd1,6'd5,6'd12,6'd9,6'd3,1'b0,1'b0,6'd10,6'd8,6'd5,6'd12,6'd3},
        '{4'd0,6'd10,4'd2,6'd8,4'd1,6'd5,6'd12,6'd9,6'd3,1'b1,1'b0,6'd10,6'd8,6'd5,6'd9,6'd3},
        '{4'd1,6'd4,4'd5,6'd5,4'd2,6'd3,6'd3,6'd10,6'd1,1'b0,1'b0,6'd6,6'd6,6'd3,6'd6,6'd3},
        '{4'd1,6'd4,4'd5,6'd5,4'd2,6'd3,6'd3,6'd10,6'd1,1'b1,1'b0,6'd6,6'd6,6'd3,6'd10,6'd3},
        '{4'd3,6'd2,4'd0,6'd1,4'd4,6'd2,6'd0,6'd0,6'd4,1'b1,1'b0,6'd5,6'd1,6'd5,6'd5,6'd5},
        '{4'd0,6'd10,4'd2,6'd8,4'd1,6'd5,6'd12,6'd9,6'd3,1'b0,1'b1,6'd10,6'd8,6'd5,6'd12,6'd3},
        '{4'd0,6'd10,4'd2,6'd8,4'd1,6'd5,6'd12,6'd9,6'd3,1'b1,1'b1,6'd10,6'd8,6'd5,6'd9,6'd3},
        '{4'd15,6'd63,4'd15,6'd63,4'd15,6'd63,6'd63,6'd63,6'd63,1'b1,1'b0,6'd63,6'd63,6'd63,6'd63,6'd63},
        '{4'd0,6'd0,4'd15,6'd0,4'd0,6'd0,6'd0,6'd0,6'd0,1'b0,1'b1,6'd16,6'd16,6'd1,6'd16,6'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic rd_i = 1'b0;
    logic slow_i = 1'b0;
    logic [WORD_W-1:0] onoff_i = '0;
    logic [WORD_W-1:0] cycle_i = '0;
    logic cs_o, we_o, re_o, capture_o, done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pbus_strobe_timer #(.WORD_W(WORD_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .rd_i(rd_i), .slow_i(slow_i),
        .onoff_i(onoff_i), .cycle_i(cycle_i),
        .cs_o(cs_o), .we_o(we_o), .re_o(re_o),
        .capture_o(capture_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_fields(input vec_t v);
        onoff_i = {2'b00, v.re_off, v.re_on, v.we_off, v.we_on, v.cs_off, v.cs_on};
        cycle_i = {4'h0, v.acc, 4'h0, 6'h2A, v.rcyc, v.wcyc};
        rd_i    = v.rd;
        slow_i  = v.slow;
    endtask

    // Runs one access and counts mismatching clocks per output.
    task automatic run_vec(input vec_t v, input bit intrude, input string tag);
        int m, total, e_cs, e_we, e_re, e_cap, e_done;
        m = v.slow ? 2 : 1;
        total = (int'(v.x_cyc) + 1) * m + 3;
        e_cs = 0; e_we = 0; e_re = 0; e_cap = 0; e_done = 0;
        @(negedge clk);
        apply_fields(v);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < total; i++) begin
            int  cnt;
            bit  last, act, x_cs, x_we, x_re, x_cap, x_done;
            cnt  = i / m;
            last = (i % m) == (m - 1);
            act  = cnt <= int'(v.x_cyc);
            x_cs   = act && cnt >= int'(v.cs_on) && cnt < int'(v.x_cs_off);
            x_we   = act && !v.rd && cnt >= int'(v.we_on) && cnt < int'(v.x_we_off);
            x_re   = act &&  v.rd && cnt >= int'(v.re_on) && cnt < int'(v.x_re_off);
            x_cap  = act &&  v.rd && last && cnt == int'(v.x_acc);
            x_done = act && last && cnt == int'(v.x_cyc);
            if (cs_o      !== x_cs)   e_cs++;
            if (we_o      !== x_we)   e_we++;
            if (re_o      !== x_re)   e_re++;
            if (capture_o !== x_cap)  e_cap++;
            if (done_o    !== x_done) e_done++;
            if (intrude && i == 3) begin
                onoff_i = 32'h0000_0000;
                cycle_i = 32'h0000_0041;
                rd_i    = ~v.rd;
                slow_i  = ~v.slow;
                start_i = 1'b1;
            end
            if (intrude && i == 4) start_i = 1'b0;
            @(negedge clk);
        end
        check(e_cs == 0,   {tag, " R2 R3 R5 R8 cs clocks"}, e_cs, 0);
        check(e_we == 0,   {tag, " R3 R4 we clocks"}, e_we, 0);
        check(e_re == 0,   {tag, " R3 R4 re clocks"}, e_re, 0);
        check(e_cap == 0,  {tag, " R7 capture clocks"}, e_cap, 0);
        check(e_done == 0, {tag, " R6 R8 done clocks"}, e_done, 0);
    endtask

    task automatic expect_quiet(input string tag);
        int busy;
        busy = int'(cs_o) + int'(we_o) + int'(re_o) + int'(capture_o) + int'(done_o);
        check(busy == 0, tag, busy, 0);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        expect_quiet("R1 outputs during reset");
        rst = 1'b0;
        @(negedge clk);
        expect_quiet("R1 outputs after reset");
        repeat (3) @(negedge clk);
        expect_quiet("R1 idle without start");

        for (int k = 0; k < NVEC; k++) begin
            run_vec(VECS[k], 1'b0, $sformatf("vec%0d", k));
        end

        // R9: second start with other settings while the first access runs
        run_vec(VECS[0], 1'b1, "R9 start during write");
        run_vec(VECS[6], 1'b1, "R9 start during slow read");

        // R1: reset abandons an access in progress
        @(negedge clk);
        apply_fields(VECS[7]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_quiet("R1 reset mid-access");
        repeat (4) @(negedge clk);
        expect_quiet("R1 stays idle after mid-access reset");

        // fresh access after reset still works
        run_vec(VECS[2], 1'b0, "post-reset");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule